// File: doc/BRIEF.md
# Loop Footprint Warp Throttler

This block sits beside a warp issue stage and decides, one bit per warp, whether that warp may issue. It does not wait for cache misses to show that the L1 is thrashing. Instead it predicts how many cache lines each warp will touch inside the loop it is running. A warp with no divergence touches few lines, and a warp whose loads scatter across its active lanes touches many. The block then lets warps issue only while their combined predicted footprint fits the cache.

Each warp slot holds one tracking entry, driven by a small state machine. The entry has three states:

- `WS_OUT`: the warp is not inside any loop.
- `WS_LOOP`: the warp is inside one loop.
- `WS_INNER`: the warp is inside a loop nested in another loop.

The entry moves between states on these transitions:

- `enter`: `WS_OUT` to `WS_LOOP` on a loop begin.
- `nest`: `WS_LOOP` to `WS_INNER` on a loop begin.
- `deepen`: `WS_INNER` to `WS_INNER` on a loop begin.
- `unnest`: `WS_INNER` to `WS_LOOP` on a loop end at depth 2.
- `rise`: `WS_INNER` to `WS_INNER` on a loop end at a depth above 2.
- `leave`: `WS_LOOP` to `WS_OUT` on a loop end.

While a warp is in a loop, load descriptors build up its prediction. The prediction is then scaled by the warp's current active-lane count.

The per-warp predictions are added in ascending warp index, with warp 0 treated as the oldest. A warp is allowed to issue when the running total up to and including that warp does not exceed the capacity.

Events come in on a single event port, at most one per cycle. The issue-allow output is combinational from the entry state, so an event accepted on a clock edge is reflected right after that edge.

Top module: `lft_throttle`

## Requirements
- R1: After reset every warp is outside any loop, its active-lane count equals LANES, and every issue_allow bit is 1.
- R2: An event is acted on only in a cycle where ev_valid is 1. ev_kind encodes the event: 2'b00 load descriptor, 2'b01 loop begin, 2'b10 loop end, 2'b11 active-lane update (ev_lanes becomes the warp's count).
- R3: Each divergent load descriptor (ev_divergent=1) for a warp in a loop adds the warp's active-lane count, in lines, to its footprint. Every such descriptor counts, even a repeat.
- R4: A converged load descriptor (ev_divergent=0) adds 2 lines the first time its class ev_class is seen in the current prediction. Further converged loads of that class add nothing.
- R5: The footprint follows the current active-lane count, so lowering the count lowers the footprint of loads already recorded.
- R6: A loop begin from outside starts an empty prediction, with no classes seen. A loop end of the outermost loop returns the warp to a footprint of 0.
- R7: A loop begin while already inside a loop replaces the prediction with an empty one. A loop end that leaves an inner loop keeps the prediction unchanged.
- R8: Footprints are summed in ascending warp index. A warp inside a loop has issue_allow=1 exactly when the sum up to and including that warp is at most CAP_LINES.
- R9: A warp outside any loop contributes 0 lines and always has issue_allow=1.
- R10: A load descriptor or loop end for a warp outside any loop has no effect.
- R11: The divergent-load count saturates at 2^CNT_W-1 (15 by default). The nesting depth saturates at 2^DEPTH_W-1 (7 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | Event kind (see R2) |
| ev_warp | input | WID_W | Warp the event refers to |
| ev_divergent | input | 1 | Load descriptor is divergent |
| ev_class | input | CLS_W | Equivalence class of the load |
| ev_lanes | input | LANE_W | New active-lane count for a lane update |
| issue_allow | output | NUM_WARPS | Per-warp permission to issue |

## Verification
The hardest situations to reach are the nesting corners. These are the depth counter saturating, and a prediction that an inner loop replaced and that must survive the inner exit. Only the allow bits are visible from the ports. The stimulus therefore builds footprints that sit exactly on the capacity or two lines above it. With that setup, each clear, keep or saturation flips or holds a specific allow bit. The tests also issue more loop begins than the depth can hold, then count loop ends until the warp is released.

// File: rtl/lft_pkg.sv
package lft_pkg;

    typedef enum logic [1:0] {
        EV_LOAD  = 2'b00,
        EV_BEGIN = 2'b01,
        EV_END   = 2'b10,
        EV_LANES = 2'b11
    } ev_kind_e;

    typedef enum logic [1:0] {
        WS_OUT   = 2'b00,
        WS_LOOP  = 2'b01,
        WS_INNER = 2'b10
    } wstate_e;

endpackage

// File: rtl/lft_warp_entry.sv
module lft_warp_entry
    import lft_pkg::*;
#(
    parameter int LANES       = 32,
    parameter int NUM_CLASSES = 8,
    parameter int CNT_W       = 4,
    parameter int DEPTH_W     = 3,
    parameter int LANE_W      = 6,
    parameter int CLS_W       = 3,
    parameter int FP_W        = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  ev_kind_e          kind,
    input  logic              divergent,
    input  logic [CLS_W-1:0]  cls,
    input  logic [LANE_W-1:0] lanes_in,
    output logic [FP_W-1:0]   footprint,
    output logic              in_loop
);

    localparam int DIV_MAX   = (1 << CNT_W) - 1;
    localparam int DEPTH_MAX = (1 << DEPTH_W) - 1;
    localparam int CONV_W    = $clog2(NUM_CLASSES + 1);

    wstate_e                  state, state_nxt;
    logic [DEPTH_W-1:0]       depth;
    logic [CNT_W-1:0]         div_cnt;
    logic [NUM_CLASSES-1:0]   seen;
    logic [LANE_W-1:0]        lanes;
    logic [CONV_W-1:0]        conv;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_OUT;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (hit) begin
            unique case (state)
                WS_OUT: begin
                    if (kind == EV_BEGIN) state_nxt = WS_LOOP;      // enter
                end
                WS_LOOP: begin
                    if (kind == EV_BEGIN)    state_nxt = WS_INNER;  // nest
                    else if (kind == EV_END) state_nxt = WS_OUT;    // leave
                end
                WS_INNER: begin
                    if (kind == EV_END && depth == DEPTH_W'(2))
                        state_nxt = WS_LOOP;                        // unnest
                end
                default: state_nxt = WS_OUT;
            endcase
        end
    end

    // prediction storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth   <= '0;
            div_cnt <= '0;
            seen    <= '0;
            lanes   <= LANE_W'(LANES);
        end else if (hit) begin
            unique case (kind)
                EV_BEGIN: begin
                    div_cnt <= '0;
                    seen    <= '0;
                    if (state == WS_OUT)
                        depth <= DEPTH_W'(1);
                    else if (depth != DEPTH_W'(DEPTH_MAX))
                        depth <= depth + DEPTH_W'(1);
                end
                EV_END: begin
                    if (state == WS_LOOP) begin
                        div_cnt <= '0;
                        seen    <= '0;
                        depth   <= '0;
                    end else if (state == WS_INNER) begin
                        depth <= depth - DEPTH_W'(1);
                    end
                end
                EV_LOAD: begin
                    if (state != WS_OUT) begin
                        if (divergent) begin
                            if (div_cnt != CNT_W'(DIV_MAX))
                                div_cnt <= div_cnt + CNT_W'(1);
                        end else begin
                            seen[cls] <= 1'b1;
                        end
                    end
                end
                EV_LANES: lanes <= lanes_in;
            endcase
        end
    end

    always_comb begin
        conv = '0;
        for (int c = 0; c < NUM_CLASSES; c++)
            conv = conv + CONV_W'(seen[c]);
    end

    // outputs
    always_comb begin
        in_loop = (state != WS_OUT);
        if (state == WS_OUT)
            footprint = '0;
        else
            footprint = FP_W'(div_cnt) * FP_W'(lanes) + (FP_W'(conv) << 1);
    end

    AST_OUT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        state == WS_OUT |-> (div_cnt == '0 && seen == '0 && depth == '0)); // R6
    AST_LOOP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        state == WS_LOOP |-> depth == DEPTH_W'(1)); // R7
    AST_INNER_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        state == WS_INNER |-> depth >= DEPTH_W'(2)); // R7
    AST_BEGIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == EV_BEGIN) |=> (div_cnt == '0 && seen == '0)); // R7
    AST_DIV_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == EV_LOAD && divergent && state != WS_OUT
         && div_cnt == CNT_W'(DIV_MAX)) |=> div_cnt == CNT_W'(DIV_MAX)); // R11
    AST_END_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == EV_END && state == WS_OUT) |=> state == WS_OUT); // R10

endmodule

// File: rtl/lft_prefix_gate.sv
module lft_prefix_gate #(
    parameter int NUM_WARPS = 4,
    parameter int FP_W      = 9,
    parameter int SUM_W     = 12,
    parameter int CAP_LINES = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_WARPS-1:0][FP_W-1:0] fp,
    input  logic [NUM_WARPS-1:0]           in_loop,
    output logic [NUM_WARPS-1:0]           allow
);

    logic [SUM_W-1:0] pre [NUM_WARPS];

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_chain
        if (w == 0) begin : g_first
            assign pre[w] = SUM_W'(fp[w]);
        end else begin : g_next
            assign pre[w] = pre[w-1] + SUM_W'(fp[w]);
            AST_PREFIX_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
                (in_loop[w-1] && !allow[w-1] && in_loop[w]) |-> !allow[w]); // R8
        end
        assign allow[w] = !in_loop[w] || (pre[w] <= SUM_W'(CAP_LINES));
    end

endmodule

// File: rtl/lft_throttle.sv
module lft_throttle
    import lft_pkg::*;
#(
    parameter int NUM_WARPS   = 4,
    parameter int LANES       = 32,
    parameter int NUM_CLASSES = 8,
    parameter int CNT_W       = 4,
    parameter int DEPTH_W     = 3,
    parameter int CAP_LINES   = 64,
    localparam int WID_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int LANE_W = $clog2(LANES + 1),
    localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [1:0]           ev_kind,
    input  logic [WID_W-1:0]     ev_warp,
    input  logic                 ev_divergent,
    input  logic [CLS_W-1:0]     ev_class,
    input  logic [LANE_W-1:0]    ev_lanes,
    output logic [NUM_WARPS-1:0] issue_allow
);

    localparam int DIV_MAX = (1 << CNT_W) - 1;
    localparam int FP_W    = $clog2(DIV_MAX * LANES + 2 * NUM_CLASSES + 1);
    localparam int SUM_W   = FP_W + $clog2(NUM_WARPS) + 1;

    ev_kind_e                       kind;
    logic [NUM_WARPS-1:0][FP_W-1:0] fp;
    logic [NUM_WARPS-1:0]           in_loop;

    assign kind = ev_kind_e'(ev_kind);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic hit;
        assign hit = ev_valid && (ev_warp == WID_W'(w));

        lft_warp_entry #(
            .LANES(LANES), .NUM_CLASSES(NUM_CLASSES), .CNT_W(CNT_W),
            .DEPTH_W(DEPTH_W), .LANE_W(LANE_W), .CLS_W(CLS_W), .FP_W(FP_W)
        ) u_entry (
            .clk(clk), .rst_n(rst_n), .hit(hit), .kind(kind),
            .divergent(ev_divergent), .cls(ev_class), .lanes_in(ev_lanes),
            .footprint(fp[w]), .in_loop(in_loop[w])
        );
    end

    lft_prefix_gate #(
        .NUM_WARPS(NUM_WARPS), .FP_W(FP_W), .SUM_W(SUM_W), .CAP_LINES(CAP_LINES)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .fp(fp), .in_loop(in_loop), .allow(issue_allow)
    );

    AST_KIND_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> !$isunknown(ev_kind)); // R2
    AST_OUT_WARP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop[0] && fp[0] <= FP_W'(CAP_LINES)) |-> issue_allow[0]); // R8

endmodule

// File: tb/lft_throttle_test.sv
module lft_throttle_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [1:0] ev_kind = 2'b00;
    logic [1:0] ev_warp = '0;
    logic       ev_divergent = 1'b0;
    logic [2:0] ev_class = '0;
    logic [5:0] ev_lanes = '0;
    logic [3:0] issue_allow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [1:0] K_LOAD = 2'b00, K_BEGIN = 2'b01, K_END = 2'b10, K_LANES = 2'b11;

    always #4 clk = ~clk;

    lft_throttle uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_warp(ev_warp), .ev_divergent(ev_divergent), .ev_class(ev_class),
        .ev_lanes(ev_lanes), .issue_allow(issue_allow)
    );

    task automatic send(input logic vld, input logic [1:0] k, input int w,
                        input logic dv, input int cl, input int ln);
        @(negedge clk);
        ev_valid = vld; ev_kind = k; ev_warp = 2'(w);
        ev_divergent = dv; ev_class = 3'(cl); ev_lanes = 6'(ln);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic ev(input logic [1:0] k, input int w, input logic dv, input int cl);
        send(1'b1, k, w, dv, cl, 0);
    endtask

    task automatic set_lanes(input int w, input int ln);
        send(1'b1, K_LANES, w, 1'b0, 0, ln);
    endtask

    task automatic chk(input logic [3:0] exp, input string req);
        n_checks++;
        if (issue_allow !== exp) begin
            n_fail++;
            $display("FAIL %s: issue_allow=%b expected=%b", req, issue_allow, exp);
        end
    endtask

    task automatic cleanup();
        for (int w = 0; w < 4; w++) begin
            for (int i = 0; i < 8; i++) ev(K_END, w, 1'b0, 0);
            set_lanes(w, 32);
        end
    endtask

    task automatic t_reset();
        chk(4'hF, "R1 reset allow");
    endtask

    task automatic t_divergent_boundary();
        ev(K_BEGIN, 0, 1'b0, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        chk(4'hF, "R3 two divergent loads = 64 lines, inclusive cap");
        ev(K_LOAD, 0, 1'b0, 3);
        chk(4'hE, "R3 plus converged = 66 blocks warp0, others free R9");
    endtask

    task automatic t_lanes_dedup();
        set_lanes(0, 31);
        chk(4'hF, "R5 lane drop to 31 gives 64");
        ev(K_LOAD, 0, 1'b0, 3);
        chk(4'hF, "R4 repeated class adds nothing");
        ev(K_LOAD, 0, 1'b0, 4);
        chk(4'hE, "R4 new class adds 2");
        cleanup();
    endtask

    task automatic t_order();
        ev(K_BEGIN, 0, 1'b0, 0);
        ev(K_LOAD, 0, 1'b0, 3);
        ev(K_BEGIN, 1, 1'b0, 0);
        set_lanes(1, 31);
        ev(K_LOAD, 1, 1'b1, 0);
        ev(K_LOAD, 1, 1'b1, 0);
        chk(4'hF, "R8 prefix 2+62 = 64 allowed");
        ev(K_LOAD, 1, 1'b0, 0);
        chk(4'b1101, "R8 prefix 66 blocks warp1 only");
        ev(K_BEGIN, 2, 1'b0, 0);
        ev(K_LOAD, 2, 1'b0, 1);
        chk(4'b1001, "R8 R9 warp2 blocked, warp3 outside free");
        ev(K_END, 0, 1'b0, 0);
        chk(4'b1011, "R6 outer end zeroes warp0");
        ev(K_BEGIN, 0, 1'b0, 0);
        ev(K_LOAD, 0, 1'b0, 3);
        chk(4'b1001, "R6 new loop starts with no classes seen");
        cleanup();
    endtask

    task automatic t_nested();
        ev(K_BEGIN, 0, 1'b0, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b0, 0);
        chk(4'hE, "R7 outer prediction 66");
        ev(K_BEGIN, 0, 1'b0, 0);
        chk(4'hF, "R7 inner begin replaces prediction");
        ev(K_LOAD, 0, 1'b0, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        chk(4'hE, "R7 inner prediction 66");
        ev(K_END, 0, 1'b0, 0);
        chk(4'hE, "R7 inner end keeps prediction");
        ev(K_END, 0, 1'b0, 0);
        chk(4'hF, "R6 outer end clears");
        cleanup();
    endtask

    task automatic t_ignore();
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_END, 0, 1'b0, 0);
        ev(K_BEGIN, 0, 1'b0, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        chk(4'hF, "R10 loads outside loop ignored");
        send(1'b0, K_LOAD, 0, 1'b0, 5, 0);
        chk(4'hF, "R2 event without ev_valid ignored");
        ev(K_LOAD, 0, 1'b0, 5);
        chk(4'hE, "R2 valid load encoding 00 applied");
        cleanup();
    endtask

    task automatic t_saturate();
        set_lanes(0, 4);
        ev(K_BEGIN, 0, 1'b0, 0);
        for (int i = 0; i < 20; i++) ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b0, 1);
        ev(K_LOAD, 0, 1'b0, 2);
        chk(4'hF, "R11 divergent count saturates at 15 (60+4)");
        ev(K_LOAD, 0, 1'b0, 3);
        chk(4'hE, "R11 saturated plus class = 66");
        cleanup();
        for (int i = 0; i < 9; i++) ev(K_BEGIN, 0, 1'b0, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b1, 0);
        ev(K_LOAD, 0, 1'b0, 0);
        for (int i = 0; i < 6; i++) ev(K_END, 0, 1'b0, 0);
        chk(4'hE, "R11 depth saturated at 7, six ends keep loop");
        ev(K_END, 0, 1'b0, 0);
        chk(4'hF, "R11 seventh end leaves loop");
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divergent_boundary();
        t_lanes_dedup();
        t_order();
        t_nested();
        t_ignore();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule